// File: doc/BRIEF.md
# Credit-Gated DMA Command Throttle

This block decides, cycle by cycle, whether one DMA channel may issue its next read command (source side) and its next write command (destination side). A consumer or producer in the fabric returns credits over a valid/ready handshake. The credits pass through a small token FIFO and then collect in a saturating pool. A two-bit side-select input chooses which sides are credit-controlled. Each command on a controlled side spends one credit, and a controlled side with an empty pool stays stalled. A side that is not selected issues its commands freely.

While the channel is off, incoming credits are accepted and thrown away, so nothing is kept. An error-recovery pulse turns the channel off at once and empties the pool and the FIFO. The channel stays off until the enable input is dropped and raised again. When only the destination side is credit-controlled, a registered comparison of shared-buffer occupancy against a programmable threshold holds back reads. This stops one channel from filling the common buffer.

Top module: `dmathr_cmd_throttle`

## Requirements
- R1: The credit pool holds at most CRD_MAX credits (default 32). With commands stalled and credits offered without pause, the channel takes in exactly CRD_MAX plus FIFO_DEPTH credits and can then issue exactly that many commands.
- R2: Every command issued on a controlled side spends exactly one credit, so the total number of controlled commands equals the total number of credits accepted. When both sides are controlled and one credit is left, the read takes it and the write waits.
- R3: A controlled side issues no command while the pool is empty, even if its request is held high.
- R4: side_i bit 0 puts reads under credit control and bit 1 puts writes under credit control. A side whose bit is 0 issues in every active cycle in which it requests, whatever the credit state.
- R5: While the channel is active, crd_ready_o is low exactly when the FIFO holds FIFO_DEPTH credits, and a credit moves into the pool no earlier than the cycle after its handshake.
- R6: While the channel is inactive, crd_ready_o is high and every credit offered is discarded. After the channel is enabled, no controlled command issues until a new credit arrives.
- R7: An err_rec_i pulse drives run_o low in the same cycle, empties pool and FIFO, and keeps run_o low while en_i stays high. run_o returns only after en_i has been low for at least one cycle.
- R8: When side_i is 2'b10, reads stop in the cycle after a clock edge at which occ_i was strictly greater than occ_thr_i. Equality does not block, and the rule has no effect in any other side setting.
- R9: A credit that enters the pool in the same cycle as a controlled command leaves the pool count unchanged. A steady stream of one credit and one command per cycle keeps issuing every cycle.
- R10: No command issues while run_o is low. run_o is high exactly when en_i is high, err_rec_i is low and no recovery lock is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Channel enable request |
| err_rec_i | input | 1 | Error-recovery done pulse |
| side_i | input | 2 | Bit 0: reads credit-controlled; bit 1: writes credit-controlled |
| crd_valid_i | input | 1 | A credit is offered |
| crd_ready_o | output | 1 | The credit is taken (or discarded while inactive) |
| occ_i | input | OCC_W | Shared-buffer cells in use by this channel |
| occ_thr_i | input | OCC_W | Occupancy threshold for reads |
| rd_req_i | input | 1 | A read command is pending |
| wr_req_i | input | 1 | A write command is pending |
| rd_issue_o | output | 1 | Read command issues this cycle |
| wr_issue_o | output | 1 | Write command issues this cycle |
| run_o | output | 1 | Channel is active |

## Verification
The bench builds the block with the default values: CRD_MAX of 32, FIFO_DEPTH of 4 and 8-bit occupancy. With these values, a flood of 36 credits fills the pool to its cap and the FIFO to full, which brings saturation and backpressure within reach in a few dozen cycles. The 8-bit occupancy lets random thresholds fall both above and below the occupancy, including the equality case. The small FIFO also means that random credit bursts and random enable and error toggles hit the full, empty and flush paths many times in a few thousand cycles.

// File: rtl/dmathr_pkg.sv
package dmathr_pkg;
    typedef enum logic [1:0] {
        SIDE_NONE = 2'b00,
        SIDE_RD   = 2'b01,
        SIDE_WR   = 2'b10,
        SIDE_BOTH = 2'b11
    } side_e;
endpackage

// File: rtl/dmathr_credit_fifo.sv
module dmathr_credit_fifo #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic push_vld_i,
    input  logic pop_i,
    output logic ready_o,
    output logic avail_o
);
    localparam int FW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [FW-1:0] fill;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     push;

    always_comb begin
        st_d    = st_q;
        ready_o = !active_i || (st_q.fill < FW'(DEPTH));
        avail_o = (st_q.fill != '0);
        push    = active_i && push_vld_i && ready_o;
        if (!active_i) begin
            st_d.fill = '0;
        end else begin
            st_d.fill = st_q.fill + FW'(push) - FW'(pop_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.fill <= FW'(DEPTH)); // R5
    AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (st_q.fill != '0)); // R5
    AST_FIFO_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (st_q.fill == '0)); // R6
endmodule

// File: rtl/dmathr_credit_pool.sv
module dmathr_credit_pool
    import dmathr_pkg::*;
#(
    parameter int CRD_MAX = 32
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active_i,
    input  side_e side_i,
    input  logic  rd_req_i,
    input  logic  wr_req_i,
    input  logic  occ_block_i,
    input  logic  fifo_avail_i,
    output logic  rd_issue_o,
    output logic  wr_issue_o,
    output logic  pop_o
);
    localparam int CW = $clog2(CRD_MAX + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } pool_st_t;

    pool_st_t      st_d, st_q;
    logic          rd_ctl, wr_ctl, rd_use, wr_use, has1, has2;
    logic [CW-1:0] after;

    always_comb begin
        st_d       = st_q;
        rd_ctl     = side_i[0];
        wr_ctl     = side_i[1];
        has1       = (st_q.cnt != '0);
        has2       = (st_q.cnt > CW'(1));
        rd_issue_o = active_i && rd_req_i && (!rd_ctl || has1) && !occ_block_i;
        rd_use     = rd_issue_o && rd_ctl;
        wr_issue_o = active_i && wr_req_i && (!wr_ctl || (rd_use ? has2 : has1));
        wr_use     = wr_issue_o && wr_ctl;
        after      = st_q.cnt - CW'(rd_use) - CW'(wr_use);
        pop_o      = active_i && fifo_avail_i && (after < CW'(CRD_MAX));
        st_d.cnt   = active_i ? (after + CW'(pop_o)) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(CRD_MAX)); // R1
    AST_NO_CREDIT_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (side_i[0] && st_q.cnt == '0) |-> !rd_issue_o); // R3
    AST_NO_CREDIT_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (side_i[1] && st_q.cnt == '0) |-> !wr_issue_o); // R3
    AST_OCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (side_i == SIDE_WR && occ_block_i) |-> !rd_issue_o); // R8
    AST_POOL_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> (st_q.cnt == '0)); // R6
    AST_BALANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && pop_o && (rd_use ^ wr_use)) |=> (st_q.cnt == $past(st_q.cnt))); // R9
endmodule

// File: rtl/dmathr_occ_guard.sv
module dmathr_occ_guard #(
    parameter int OCC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [OCC_W-1:0] occ_i,
    input  logic [OCC_W-1:0] thr_i,
    output logic             over_o
);
    typedef struct packed {
        logic over;
    } occ_st_t;

    occ_st_t st_d, st_q;

    always_comb begin
        st_d.over = (occ_i > thr_i);
        over_o    = st_q.over;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_OCC_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_i > thr_i) |=> over_o); // R8
endmodule

// File: rtl/dmathr_cmd_throttle.sv
module dmathr_cmd_throttle
    import dmathr_pkg::*;
#(
    parameter int CRD_MAX    = 32,
    parameter int FIFO_DEPTH = 4,
    parameter int OCC_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             err_rec_i,
    input  logic [1:0]       side_i,
    input  logic             crd_valid_i,
    output logic             crd_ready_o,
    input  logic [OCC_W-1:0] occ_i,
    input  logic [OCC_W-1:0] occ_thr_i,
    input  logic             rd_req_i,
    input  logic             wr_req_i,
    output logic             rd_issue_o,
    output logic             wr_issue_o,
    output logic             run_o
);
    typedef struct packed {
        logic lock;
    } top_st_t;

    top_st_t st_d, st_q;
    side_e   side;
    logic    occ_over, occ_block, fifo_avail, pop;

    always_comb begin
        side      = side_e'(side_i);
        run_o     = en_i && !err_rec_i && !st_q.lock;
        occ_block = (side == SIDE_WR) && occ_over;
        st_d      = st_q;
        if (err_rec_i)  st_d.lock = 1'b1;
        else if (!en_i) st_d.lock = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    dmathr_occ_guard #(.OCC_W(OCC_W)) occ_i0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .occ_i  (occ_i),
        .thr_i  (occ_thr_i),
        .over_o (occ_over)
    );

    dmathr_credit_fifo #(.DEPTH(FIFO_DEPTH)) fifo_i0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (run_o),
        .push_vld_i (crd_valid_i),
        .pop_i      (pop),
        .ready_o    (crd_ready_o),
        .avail_o    (fifo_avail)
    );

    dmathr_credit_pool #(.CRD_MAX(CRD_MAX)) pool_i0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .active_i     (run_o),
        .side_i       (side),
        .rd_req_i     (rd_req_i),
        .wr_req_i     (wr_req_i),
        .occ_block_i  (occ_block),
        .fifo_avail_i (fifo_avail),
        .rd_issue_o   (rd_issue_o),
        .wr_issue_o   (wr_issue_o),
        .pop_o        (pop)
    );

    AST_ERR_DROPS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        err_rec_i |=> !run_o); // R7
    AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && en_i) |=> !run_o); // R7
    AST_IDLE_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> (!rd_issue_o && !wr_issue_o)); // R10
    AST_IDLE_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_o |-> crd_ready_o); // R6
endmodule

// File: tb/dmathr_cmd_throttle_tb_top.sv
module dmathr_cmd_throttle_tb_top;
    localparam int CRD_MAX    = 32;
    localparam int FIFO_DEPTH = 4;
    localparam int OCC_W      = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en = 1'b0, err = 1'b0, crd_vld = 1'b0, rd_req = 1'b0, wr_req = 1'b0;
    logic [1:0]       side = 2'b00;
    logic [OCC_W-1:0] occ = '0, thr = '0;
    logic             crd_rdy, rd_iss, wr_iss, run;

    int checks = 0, failures = 0;
    int m_cnt = 0, m_fifo = 0;
    bit m_lock = 0, m_occ = 0;
    bit o_rd, o_wr, o_run, o_rdy, o_push;
    int n_rd, n_wr, n_push;
    bit done = 0;

    always #10 clk = ~clk;

    dmathr_cmd_throttle #(.CRD_MAX(CRD_MAX), .FIFO_DEPTH(FIFO_DEPTH), .OCC_W(OCC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .err_rec_i(err), .side_i(side),
        .crd_valid_i(crd_vld), .crd_ready_o(crd_rdy), .occ_i(occ), .occ_thr_i(thr),
        .rd_req_i(rd_req), .wr_req_i(wr_req), .rd_issue_o(rd_iss), .wr_issue_o(wr_iss),
        .run_o(run)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit exp_run();
        return en && !err && !m_lock;
    endfunction

    // One cycle: compare outputs with the model, then advance the model.
    task automatic step();
        bit act, blk, e_rd, e_wr, e_rdy, ru, wu, push, pop;
        int after;
        #1;
        act   = exp_run();
        blk   = (side == 2'b10) && m_occ;
        e_rd  = act && rd_req && (!side[0] || m_cnt >= 1) && !blk;
        ru    = e_rd && side[0];
        e_wr  = act && wr_req && (!side[1] || m_cnt >= 1 + int'(ru));
        wu    = e_wr && side[1];
        e_rdy = !act || (m_fifo < FIFO_DEPTH);
        chk(run == act, "R7 run_o", run, act);
        chk(rd_iss == e_rd, "R3 rd_issue_o", rd_iss, e_rd);
        chk(wr_iss == e_wr, "R2 wr_issue_o", wr_iss, e_wr);
        chk(crd_rdy == e_rdy, "R5 crd_ready_o", crd_rdy, e_rdy);
        o_rd = rd_iss; o_wr = wr_iss; o_run = run; o_rdy = crd_rdy;
        o_push = crd_vld && crd_rdy && run;
        n_rd += int'(rd_iss); n_wr += int'(wr_iss); n_push += int'(o_push);
        push  = act && crd_vld && e_rdy;
        after = m_cnt - int'(ru) - int'(wu);
        pop   = act && (m_fifo > 0) && (after < CRD_MAX);
        @(posedge clk);
        if (!act) begin
            m_fifo = 0; m_cnt = 0;
        end else begin
            m_fifo = m_fifo + int'(push) - int'(pop);
            m_cnt  = after + int'(pop);
        end
        if (err)      m_lock = 1;
        else if (!en) m_lock = 0;
        m_occ = (occ > thr);
        @(negedge clk);
    endtask

    task automatic quiet();
        crd_vld = 0; rd_req = 0; wr_req = 0; err = 0;
    endtask

    task automatic flush_on(input logic [1:0] s);
        quiet(); en = 0; step(); side = s; en = 1; step();
    endtask

    task automatic zero_counts();
        n_rd = 0; n_wr = 0; n_push = 0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        // Reset state: inactive, no commands, credit input open
        #1;
        chk(run == 0, "R10 reset run_o", run, 0);
        chk(rd_iss == 0 && wr_iss == 0, "R10 reset issue", int'(rd_iss) + int'(wr_iss), 0);
        chk(crd_rdy == 1, "R6 reset crd_ready_o", crd_rdy, 1);
        #1;

        // R6: credits while disabled are discarded
        zero_counts();
        crd_vld = 1;
        for (int i = 0; i < 5; i++) begin
            step();
            chk(o_rdy == 1, "R6 ready while off", o_rdy, 1);
        end
        crd_vld = 0; side = 2'b01; en = 1; rd_req = 1;
        zero_counts();
        repeat (5) step();
        chk(n_rd == 0, "R6 no stale credits", n_rd, 0);

        // R1 and R5: flood credits with reads stalled
        flush_on(2'b01);
        zero_counts();
        crd_vld = 1;
        repeat (50) step();
        chk(n_push == CRD_MAX + FIFO_DEPTH, "R1 credits accepted", n_push, CRD_MAX + FIFO_DEPTH);
        chk(o_rdy == 0, "R5 backpressure when full", o_rdy, 0);
        crd_vld = 0; rd_req = 1;
        zero_counts();
        repeat (50) step();
        chk(n_rd == CRD_MAX + FIFO_DEPTH, "R1 reads from saturated pool", n_rd, CRD_MAX + FIFO_DEPTH);

        // R9 and R2: credit in and command out in the same cycle
        flush_on(2'b01);
        crd_vld = 1; repeat (2) step();
        crd_vld = 0; repeat (3) step();
        zero_counts();
        crd_vld = 1; rd_req = 1;
        repeat (10) step();
        chk(n_rd == 10, "R9 steady stream issues each cycle", n_rd, 10);
        crd_vld = 0;
        repeat (6) step();
        chk(n_rd == 12, "R2 one credit per read", n_rd, 12);

        // R4: uncontrolled sides ignore credits
        flush_on(2'b00);
        zero_counts();
        rd_req = 1; wr_req = 1;
        repeat (5) step();
        chk(n_rd == 5 && n_wr == 5, "R4 both free", n_rd + n_wr, 10);
        flush_on(2'b10);
        zero_counts();
        rd_req = 1; wr_req = 1;
        repeat (5) step();
        chk(n_rd == 5, "R4 reads free in write-only mode", n_rd, 5);
        chk(n_wr == 0, "R3 writes held with empty pool", n_wr, 0);

        // R2: last credit goes to the read
        flush_on(2'b11);
        crd_vld = 1; step(); crd_vld = 0; repeat (3) step();
        rd_req = 1; wr_req = 1;
        step();
        chk(o_rd == 1 && o_wr == 0, "R2 read takes last credit", int'(o_rd) * 2 + int'(o_wr), 2);
        step();
        chk(o_rd == 0 && o_wr == 0, "R3 nothing after last credit", int'(o_rd) + int'(o_wr), 0);

        // R7: error recovery
        flush_on(2'b01);
        crd_vld = 1; repeat (3) step(); crd_vld = 0; repeat (3) step();
        err = 1; step();
        chk(o_run == 0, "R7 run drops with err", o_run, 0);
        err = 0; rd_req = 1;
        zero_counts();
        repeat (3) step();
        chk(o_run == 0 && n_rd == 0, "R7 locked while en high", int'(o_run) + n_rd, 0);
        en = 0; step(); en = 1; step();
        chk(o_run == 1, "R7 run back after re-enable", o_run, 1);
        zero_counts();
        repeat (3) step();
        chk(n_rd == 0, "R7 credits flushed", n_rd, 0);

        // R8: occupancy threshold in write-only mode
        flush_on(2'b10);
        thr = 8'd100; occ = 8'd50; rd_req = 1;
        step();
        chk(o_rd == 1, "R8 below threshold", o_rd, 1);
        occ = 8'd101; step();
        chk(o_rd == 1, "R8 one-cycle delay", o_rd, 1);
        step();
        chk(o_rd == 0, "R8 reads stopped", o_rd, 0);
        occ = 8'd100; step(); step();
        chk(o_rd == 1, "R8 equality does not block", o_rd, 1);
        side = 2'b00; occ = 8'd200; step(); step();
        chk(o_rd == 1, "R8 no effect when writes not controlled", o_rd, 1);

        // Random traffic against the model
        quiet(); en = 1;
        for (int i = 0; i < 3000; i++) begin
            crd_vld = ($urandom % 3) != 0;
            rd_req  = ($urandom % 4) != 0;
            wr_req  = ($urandom % 4) != 0;
            err     = ($urandom % 64) == 0;
            if (($urandom % 32) == 0) en = ~en;
            if (($urandom % 128) == 0) side = 2'($urandom);
            occ = 8'($urandom); thr = 8'($urandom);
            if (($urandom % 8) == 0) thr = occ;
            step();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule